// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block sits between three banks of GPIO interrupt sources and an interrupt controller that has fewer input lines than there are pins. The banks hold 14, 24 and 32 pins, 70 level interrupt sources in all, and the controller side offers 41 lines: 38 exclusive lines and 3 shared lines, one shared line per bank. A 32-bit configuration word chooses, for each of the first 32 exclusive lines, whether the line serves a pin of the first two banks or the pin of the same number in the third bank. Any pin that does not win an exclusive line is ORed into the shared line of its own bank, so every pin reaches the controller by exactly one path.

Exclusive lines 0 to 13 pair bank-0 pins 0 to 13 with bank-2 pins 0 to 13. Lines 14 to 31 pair bank-1 pins 0 to 17 with bank-2 pins 14 to 31. Lines 32 to 37 always carry bank-1 pins 18 to 23 and no setting changes them. Software writes the configuration through a plain write-enable port and reads it back on a read-data port. Every output is registered once, so the controller sees clean levels one clock after the inputs and the configuration it was computed from.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is asserted the configuration reads back as zero and all 41 outputs are low, whatever the inputs and the write port do.
- R2: When configuration bit i is 0, exclusive line i carries bank-0 pin i for i from 0 to 13 and bank-1 pin i-14 for i from 14 to 31.
- R3: When configuration bit i is 1, exclusive line i carries bank-2 pin i.
- R4: Exclusive lines 32 to 37 carry bank-1 pins 18 to 23 in that order under every configuration.
- R5: Shared line 0 is the OR of the bank-0 pins i whose configuration bit i is 1.
- R6: Shared line 1 is the OR of the bank-1 pins j (j from 0 to 17) whose configuration bit j+14 is 1.
- R7: Shared line 2 is the OR of the bank-2 pins i whose configuration bit i is 0.
- R8: A write with the enable high loads the whole 32-bit word on the clock edge, and the read port shows it from then on; with the enable low the data on the write bus is ignored and the read value stays unchanged.
- R9: Outputs change on the clock edge after the inputs that drive them; a configuration written on an edge governs the outputs from the following edge, so the edge of the write still uses the old routing.
- R10: When exactly one of the 70 pins is high, exactly one of the 41 outputs goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration word to load |
| cfg_rdata | output | 32 | Current configuration word |
| bank0_irq | input | 14 | Interrupt levels of bank 0 |
| bank1_irq | input | 24 | Interrupt levels of bank 1 |
| bank2_irq | input | 32 | Interrupt levels of bank 2 |
| excl_irq | output | 38 | Exclusive interrupt lines |
| shared_irq | output | 3 | Shared interrupt lines, index = bank |

## Verification
The routing is driven with the configuration all zeros, all ones, an alternating pattern and random words, each under random pin levels: all-zeros and all-ones separate a swapped select polarity from a correct one, while the mixed words catch a lane wired to the wrong bit or a pin ORed into the wrong shared line. A walk of a single active pin over all 70 sources under two configurations shows any pin that is dropped or duplicated. A directed write with a bank-0 pin held high distinguishes a configuration that acts one edge early from one that waits for the registered path, and cycles with a busy write bus but the enable low show that the word is only taken when enabled.

// File: rtl/gpio_irq_router_pkg.sv
package gpio_irq_router_pkg;

   localparam int NUM_BANKS = 3;

   typedef enum logic [1:0] {
      BANK_LOW  = 2'd0,
      BANK_MID  = 2'd1,
      BANK_HIGH = 2'd2
   } bank_id_e;

   function automatic int excl_width(input int cfg_w, input int b0, input int b1);
      return cfg_w + (b1 - (cfg_w - b0));
   endfunction

endpackage

// File: rtl/gpio_irq_cfg_reg.sv
module gpio_irq_cfg_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= wdata;
      end
   end

endmodule

// File: rtl/gpio_irq_lane_mux.sv
module gpio_irq_lane_mux #(
   parameter int W   = 32,
   parameter int B0  = 14,
   localparam int B1M = W - B0
) (
   input  logic [W-1:0]   cfg,
   input  logic [B0-1:0]  b0,
   input  logic [B1M-1:0] b1m,
   input  logic [W-1:0]   b2,
   output logic [W-1:0]   lane,
   output logic [B0-1:0]  spill0,
   output logic [B1M-1:0] spill1,
   output logic [W-1:0]   spill2
);

   for (genvar i = 0; i < W; i++) begin : g_lane
      logic low_src;
      if (i < B0) begin : g_from_b0
         assign low_src   = b0[i];
         assign spill0[i] = b0[i] & cfg[i];
      end else begin : g_from_b1
         assign low_src       = b1m[i-B0];
         assign spill1[i-B0]  = b1m[i-B0] & cfg[i];
      end
      assign lane[i]   = cfg[i] ? b2[i] : low_src;
      assign spill2[i] = b2[i] & ~cfg[i];
   end

endmodule

// File: rtl/gpio_irq_share_or.sv
module gpio_irq_share_or #(
   parameter int W = 8
) (
   input  logic [W-1:0] vec,
   output logic         any
);

   assign any = |vec;

endmodule

// File: rtl/gpio_irq_out_reg.sv
module gpio_irq_out_reg #(
   parameter int W = 41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gpio_irq_router_pkg::*;
#(
   parameter  int B0_PINS  = 14,
   parameter  int B1_PINS  = 24,
   parameter  int B2_PINS  = 32,
   localparam int CFG_W    = B2_PINS,
   localparam int B1_MUXED = CFG_W - B0_PINS,
   localparam int B1_FIXED = B1_PINS - B1_MUXED,
   localparam int EXCL_W   = excl_width(CFG_W, B0_PINS, B1_PINS),
   localparam int OUT_W    = EXCL_W + NUM_BANKS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_W-1:0]    cfg_wdata,
   output logic [CFG_W-1:0]    cfg_rdata,
   input  logic [B0_PINS-1:0]  bank0_irq,
   input  logic [B1_PINS-1:0]  bank1_irq,
   input  logic [B2_PINS-1:0]  bank2_irq,
   output logic [EXCL_W-1:0]   excl_irq,
   output logic [NUM_BANKS-1:0] shared_irq
);

   if (B0_PINS < 1 || B0_PINS >= CFG_W) begin : g_bad_b0
      $error("bank 0 must be smaller than the configuration word");
   end
   if (B1_FIXED < 1) begin : g_bad_b1
      $error("bank 1 must cover the muxed lanes and keep at least one fixed pin");
   end
   if (CFG_W > 32) begin : g_bad_cfg
      $error("configuration word is limited to 32 bits");
   end

   logic [CFG_W-1:0]    cfg_q;
   logic [CFG_W-1:0]    lane;
   logic [B0_PINS-1:0]  spill0;
   logic [B1_MUXED-1:0] spill1;
   logic [CFG_W-1:0]    spill2;
   logic [NUM_BANKS-1:0] share_d;
   logic [OUT_W-1:0]    out_d;
   logic [OUT_W-1:0]    out_q;

   gpio_irq_cfg_reg #(.W(CFG_W)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_q)
   );

   gpio_irq_lane_mux #(.W(CFG_W), .B0(B0_PINS)) u_lanes (
      .cfg    (cfg_q),
      .b0     (bank0_irq),
      .b1m    (bank1_irq[B1_MUXED-1:0]),
      .b2     (bank2_irq),
      .lane   (lane),
      .spill0 (spill0),
      .spill1 (spill1),
      .spill2 (spill2)
   );

   gpio_irq_share_or #(.W(B0_PINS)) u_share_low (
      .vec (spill0),
      .any (share_d[BANK_LOW])
   );

   gpio_irq_share_or #(.W(B1_MUXED)) u_share_mid (
      .vec (spill1),
      .any (share_d[BANK_MID])
   );

   gpio_irq_share_or #(.W(CFG_W)) u_share_high (
      .vec (spill2),
      .any (share_d[BANK_HIGH])
   );

   assign out_d = {share_d, bank1_irq[B1_PINS-1:B1_MUXED], lane};

   gpio_irq_out_reg #(.W(OUT_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (out_d),
      .q     (out_q)
   );

   assign excl_irq   = out_q[EXCL_W-1:0];
   assign shared_irq = out_q[OUT_W-1:EXCL_W];
   assign cfg_rdata  = cfg_q;

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
   import gpio_irq_router_pkg::*;
#(
   parameter  int B0_PINS  = 14,
   parameter  int B1_PINS  = 24,
   parameter  int B2_PINS  = 32,
   localparam int CFG_W    = B2_PINS,
   localparam int B1_MUXED = CFG_W - B0_PINS,
   localparam int EXCL_W   = excl_width(CFG_W, B0_PINS, B1_PINS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_we,
   input logic [CFG_W-1:0]     cfg_wdata,
   input logic [CFG_W-1:0]     cfg_rdata,
   input logic [B0_PINS-1:0]   bank0_irq,
   input logic [B1_PINS-1:0]   bank1_irq,
   input logic [B2_PINS-1:0]   bank2_irq,
   input logic [EXCL_W-1:0]    excl_irq,
   input logic [NUM_BANKS-1:0] shared_irq
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   logic [CFG_W-1:0] low_src;
   assign low_src = {bank1_irq[B1_MUXED-1:0], bank0_irq};

   for (genvar i = 0; i < CFG_W; i++) begin : g_lane_chk
      assert_lane_low_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         !$past(cfg_rdata[i]) |-> excl_irq[i] == $past(low_src[i]));
      assert_lane_high_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         $past(cfg_rdata[i]) |-> excl_irq[i] == $past(bank2_irq[i]));
   end

   assert_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      excl_irq[EXCL_W-1:CFG_W] == $past(bank1_irq[B1_PINS-1:B1_MUXED]));

   assert_share_low_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      shared_irq[BANK_LOW] == |($past(bank0_irq) & $past(cfg_rdata[B0_PINS-1:0])));

   assert_share_mid_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      shared_irq[BANK_MID] ==
         |($past(bank1_irq[B1_MUXED-1:0]) & $past(cfg_rdata[CFG_W-1:B0_PINS])));

   assert_share_high_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      shared_irq[BANK_HIGH] == |($past(bank2_irq) & ~$past(cfg_rdata)));

   assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(cfg_we) |-> cfg_rdata == $past(cfg_wdata));

   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(cfg_we) |-> $stable(cfg_rdata));

   assert_one_path_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $countones($past({bank2_irq, bank1_irq, bank0_irq})) == 1
         |-> $countones({shared_irq, excl_irq}) == 1);

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
   .B0_PINS (B0_PINS),
   .B1_PINS (B1_PINS),
   .B2_PINS (B2_PINS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_wdata  (cfg_wdata),
   .cfg_rdata  (cfg_rdata),
   .bank0_irq  (bank0_irq),
   .bank1_irq  (bank1_irq),
   .bank2_irq  (bank2_irq),
   .excl_irq   (excl_irq),
   .shared_irq (shared_irq)
);

// File: tb/test_gpio_irq_router.sv
`timescale 1ns/1ps
module test_gpio_irq_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [13:0] bank0_irq = '0;
   logic [23:0] bank1_irq = '0;
   logic [31:0] bank2_irq = '0;
   logic [37:0] excl_irq;
   logic [2:0]  shared_irq;

   always #2.5 clk = ~clk;

   gpio_irq_router i_gpio_irq_router (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .bank0_irq  (bank0_irq),
      .bank1_irq  (bank1_irq),
      .bank2_irq  (bank2_irq),
      .excl_irq   (excl_irq),
      .shared_irq (shared_irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_cfg = '0;
   logic [31:0] used_cfg = '0;
   logic [37:0] exp_excl = '0;
   logic [2:0]  exp_shared = '0;
   bit          exp_single = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural model: walk the 7-bit source index bank*32+pin
   task automatic model(input logic [31:0] cfg, input logic [13:0] a,
                        input logic [23:0] b, input logic [31:0] c);
      int n_active = 0;
      exp_excl = '0;
      exp_shared = '0;
      for (int p = 0; p < 96; p++) begin
         int bank = p / 32;
         int pin  = p % 32;
         int line;
         bit own;
         logic v;
         if (bank == 0 && pin >= 14) continue;
         if (bank == 1 && pin >= 24) continue;
         if (bank == 0) begin
            v = a[pin]; line = pin; own = (cfg[pin] == 1'b0);
         end else if (bank == 1) begin
            v = b[pin];
            if (pin < 18) begin line = pin + 14; own = (cfg[pin+14] == 1'b0); end
            else begin line = 32 + (pin - 18); own = 1'b1; end
         end else begin
            v = c[pin]; line = pin; own = (cfg[pin] == 1'b1);
         end
         if (v) n_active++;
         if (own) exp_excl[line] = exp_excl[line] | v;
         else     exp_shared[bank] = exp_shared[bank] | v;
      end
      exp_single = (n_active == 1);
   endtask

   task automatic compare();
      for (int i = 0; i < 32; i++)
         chk(excl_irq[i] === exp_excl[i], used_cfg[i] ? "R3 lane" : "R2 lane",
             64'(excl_irq[i]), 64'(exp_excl[i]));
      chk(excl_irq[37:32] === exp_excl[37:32], "R4 fixed lines",
          64'(excl_irq[37:32]), 64'(exp_excl[37:32]));
      chk(shared_irq[0] === exp_shared[0], "R5 shared0", 64'(shared_irq[0]), 64'(exp_shared[0]));
      chk(shared_irq[1] === exp_shared[1], "R6 shared1", 64'(shared_irq[1]), 64'(exp_shared[1]));
      chk(shared_irq[2] === exp_shared[2], "R7 shared2", 64'(shared_irq[2]), 64'(exp_shared[2]));
      chk(cfg_rdata === m_cfg, "R8 readback", 64'(cfg_rdata), 64'(m_cfg));
      if (exp_single)
         chk($countones({shared_irq, excl_irq}) == 1, "R10 one path",
             64'($countones({shared_irq, excl_irq})), 64'd1);
   endtask

   // one cycle: check previous result, drive new stimulus, predict next result (R9 latency)
   task automatic step(input logic we, input logic [31:0] wd, input logic [13:0] a,
                       input logic [23:0] b, input logic [31:0] c);
      @(negedge clk);
      compare();
      cfg_we = we; cfg_wdata = wd;
      bank0_irq = a; bank1_irq = b; bank2_irq = c;
      model(m_cfg, a, b, c);
      used_cfg = m_cfg;
      if (we) m_cfg = wd;
   endtask

   task automatic rand_cycles(input int n, input bit allow_wr);
      for (int k = 0; k < n; k++) begin
         logic we;
         we = allow_wr ? ($urandom_range(0, 3) == 0) : 1'b0;
         step(we, $urandom, 14'($urandom), 24'($urandom), $urandom);
      end
   endtask

   task automatic walk(input logic [31:0] cfg);
      step(1'b1, cfg, '0, '0, '0);
      for (int p = 0; p < 70; p++) begin
         logic [69:0] one;
         one = 70'd1 << p;
         step(1'b0, $urandom, one[13:0], one[37:14], one[69:38]);
      end
      step(1'b0, '0, '0, '0, '0);
   endtask

   initial begin
      // R1: reset dominates busy inputs and write port
      cfg_we = 1'b1; cfg_wdata = '1;
      bank0_irq = '1; bank1_irq = '1; bank2_irq = '1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(cfg_rdata === '0, "R1 cfg in reset", 64'(cfg_rdata), 64'd0);
      chk(excl_irq === '0, "R1 excl in reset", 64'(excl_irq), 64'd0);
      chk(shared_irq === '0, "R1 shared in reset", 64'(shared_irq), 64'd0);
      cfg_we = 1'b0; cfg_wdata = '0;
      bank0_irq = '0; bank1_irq = '0; bank2_irq = '0;
      rst_n = 1'b1;

      rand_cycles(20, 1'b0);                     // cfg all zeros: R2, R4, R7
      step(1'b1, '1, '0, '0, '0);
      rand_cycles(20, 1'b0);                     // cfg all ones: R3, R5, R6
      step(1'b1, 32'hAAAA_5555, '0, '0, '0);
      rand_cycles(20, 1'b0);

      // R9: the write edge still routes with the old word
      step(1'b1, '0, '0, '0, '0);
      step(1'b1, '1, 14'h1, '0, '0);
      @(posedge clk); #1;
      chk(excl_irq[0] === 1'b1, "R9 old routing on write edge", 64'(excl_irq[0]), 64'd1);
      chk(shared_irq[0] === 1'b0, "R9 shared idle on write edge", 64'(shared_irq[0]), 64'd0);
      step(1'b0, '0, 14'h1, '0, '0);
      @(posedge clk); #1;
      chk(excl_irq[0] === 1'b0, "R9 new routing after write", 64'(excl_irq[0]), 64'd0);
      chk(shared_irq[0] === 1'b1, "R9 pin moved to shared", 64'(shared_irq[0]), 64'd1);

      walk(32'h0F0F_F0F0);                       // R10
      walk($urandom);

      rand_cycles(30, 1'b0);                     // R8: busy write bus, enable low
      rand_cycles(200, 1'b1);
      step(1'b0, '0, '0, '0, '0);
      step(1'b0, '0, '0, '0, '0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule